// File: doc/BRIEF.md
# Registration-Based Coherence Controller with Self-Invalidation

This block keeps a small set of private caches coherent for one address line. It relies on the software being free of data races. Each core's private copy of the line sits in one of three stable states: Invalid, Valid or Registered. No state is ever in flight, because every directory action completes in the cycle it is granted. A shared directory does not remember who has read the line. It records only whether the home value is current, or else which single core holds the registered, up-to-date copy.

A core can read stale data until it reaches a synchronization point. At that point software pulses the core's self-invalidate input. The cache then drops every copy it only read (Valid) and keeps the copy it wrote (Registered). A load that misses fetches data from the directory. If the line is registered, the directory forwards the owner's copy; otherwise it returns the home value. A store registers the line to the storing core. Registration takes the copy away from the previous owner.

Each core talks to the block through a request/response pair. A request is held until its response pulse appears. Requests that need the directory (load misses and registrations) are serialised by a round-robin arbiter, one per cycle. Hits complete locally.

Top module: `coh_reg_ctrl`

## Requirements
- R1: After reset every line state output reads Invalid and no response is asserted. The line state encoding is 2 bits per core: 0 Invalid, 1 Valid, 2 Registered. A first load returns the parameter HOME_INIT.
- R2: A load to an Invalid line, when granted, answers one cycle later with the fetched data and leaves the line Valid. If the directory is not registered, the data is the home value.
- R3: A load miss while another core holds the line Registered returns that owner's current data. The owner keeps its registration.
- R4: A store from any state leaves the line Registered, holding the stored word. The response data equals the stored word.
- R5: A load to a Valid or Registered line, and a store to a Registered line, answer one cycle after acceptance from the local copy. They use no directory slot. A Valid copy may be stale.
- R6: A self-invalidate pulse on a core turns its Valid line Invalid and leaves a Registered line Registered. A request from that core is not accepted in a cycle where its self-invalidate is high.
- R7: When a core registers the line, the previous owner's Registered copy becomes Invalid in the same edge. Its next load misses and sees the new owner's data.
- R8: At most one line is Registered at any time. Once a registration has been granted, the directory's recorded owner is the core whose line is Registered.
- R9: At most one directory operation is granted per cycle. The search starts at the core after the last granted one, in increasing index order with wrap-around. A losing core waits, holding its request.
- R10: Each accepted request yields exactly one single-cycle response. A request still held in the cycle its response is high is not taken again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req_valid | input | NCORE | Request held per core until its response |
| core_req_store | input | NCORE | 1 = store, 0 = load |
| core_req_wdata | input | NCORE*DW | Store word per core |
| core_sinv | input | NCORE | Self-invalidate pulse per core |
| core_resp_valid | output | NCORE | Single-cycle response per core |
| core_resp_rdata | output | NCORE*DW | Load data or stored word |
| core_line_state | output | 2*NCORE | Line state per core (0 I, 1 V, 2 R) |

## Verification
The hardest situation to reach is a race in one edge. One case is a load miss that is forwarded from an owner while another core's registration is waiting behind it in the arbiter. The other is two registrations that contend, so the first winner is revoked by the second at once. The stimulus issues paired requests to chosen cores after placing the round-robin pointer through a known history of grants. It also holds a self-invalidate high over a cycle that carries a request, and holds a request through its own response cycle. A behavioural reference model is compared with every line state and response on every clock.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_VAL = 2'd1,
    LN_REG = 2'd2
  } line_st_t;
endpackage

// File: rtl/coh_rr_arb.sv
module coh_rr_arb #(
  parameter int NCORE = 3,
  localparam int IW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCORE-1:0] req,
  output logic [NCORE-1:0] grant,
  output logic [IW-1:0]    gidx,
  output logic             gany
);
  logic [IW-1:0] last_q;

  always_comb begin
    grant = '0;
    gidx  = '0;
    gany  = 1'b0;
    for (int k = 1; k <= NCORE; k++) begin
      int idx;
      idx = int'(last_q) + k;
      if (idx >= NCORE) idx = idx - NCORE;
      if (!gany && req[idx]) begin
        gany       = 1'b1;
        grant[idx] = 1'b1;
        gidx       = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= IW'(NCORE - 1);
    else if (gany) last_q <= gidx;
  end

  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    (grant & ~req) == '0); // R9
  AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R9
  AST_WORK_CONSERVE: assert property (@(posedge clk) disable iff (rst)
    (|req) |-> gany); // R9
endmodule

// File: rtl/coh_dir.sv
module coh_dir #(
  parameter int          NCORE     = 3,
  parameter int          DW        = 16,
  parameter logic [DW-1:0] HOME_INIT = '0,
  localparam int IW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                gany,
  input  logic [IW-1:0]       gidx,
  input  logic                gstore,
  input  logic [NCORE*DW-1:0] line_data,
  output logic [DW-1:0]       fill_data,
  output logic [NCORE-1:0]    revoke,
  output logic                dir_reg,
  output logic [IW-1:0]       dir_owner
);
  logic          reg_q;
  logic [IW-1:0] owner_q;

  assign dir_reg   = reg_q;
  assign dir_owner = owner_q;
  assign fill_data = reg_q ? line_data[owner_q*DW +: DW] : HOME_INIT;

  always_comb begin
    revoke = '0;
    if (gany && gstore && reg_q && (owner_q != gidx)) revoke[owner_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q   <= 1'b0;
      owner_q <= '0;
    end else if (gany && gstore) begin
      reg_q   <= 1'b1;
      owner_q <= gidx;
    end
  end

  AST_FETCH_KEEPS_OWNER: assert property (@(posedge clk) disable iff (rst)
    (gany && !gstore) |=> $stable(owner_q) && $stable(reg_q)); // R3
  AST_LAST_REG_WINS: assert property (@(posedge clk) disable iff (rst)
    (gany && gstore) |=> reg_q && owner_q == $past(gidx)); // R8
  AST_REG_STICKY: assert property (@(posedge clk) disable iff (rst)
    reg_q |=> reg_q); // R8
endmodule

// File: rtl/coh_l1_line.sv
module coh_l1_line
  import coh_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_store,
  input  logic [DW-1:0] req_wdata,
  input  logic          sinv,
  output logic          need_dir,
  output logic          need_store,
  input  logic          grant,
  input  logic [DW-1:0] fill_data,
  input  logic          revoke,
  output line_st_t      line_state,
  output logic [DW-1:0] line_data,
  output logic          resp_valid,
  output logic [DW-1:0] resp_rdata
);
  line_st_t      st_q;
  logic [DW-1:0] data_q;
  logic          resp_q;
  logic [DW-1:0] rdata_q;
  logic          accept, hit_load, hit_store;

  assign accept     = req_valid && !resp_q && !sinv;
  assign hit_load   = accept && !req_store && (st_q != LN_INV);
  assign hit_store  = accept && req_store && (st_q == LN_REG);
  assign need_store = accept && req_store && (st_q != LN_REG);
  assign need_dir   = need_store || (accept && !req_store && (st_q == LN_INV));

  assign line_state = st_q;
  assign line_data  = data_q;
  assign resp_valid = resp_q;
  assign resp_rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= LN_INV;
      data_q  <= '0;
      resp_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      resp_q <= 1'b0;
      if (sinv && st_q == LN_VAL) st_q <= LN_INV;
      if (hit_load) begin
        resp_q  <= 1'b1;
        rdata_q <= data_q;
      end
      if (hit_store) begin
        data_q  <= req_wdata;
        resp_q  <= 1'b1;
        rdata_q <= req_wdata;
      end
      if (grant) begin
        resp_q <= 1'b1;
        if (req_store) begin
          st_q    <= LN_REG;
          data_q  <= req_wdata;
          rdata_q <= req_wdata;
        end else begin
          st_q    <= LN_VAL;
          data_q  <= fill_data;
          rdata_q <= fill_data;
        end
      end
      if (revoke) st_q <= LN_INV;
    end
  end

  AST_SINV_DROPS_VALID: assert property (@(posedge clk) disable iff (rst)
    (sinv && st_q == LN_VAL) |=> st_q == LN_INV); // R6
  AST_SINV_KEEPS_REG: assert property (@(posedge clk) disable iff (rst)
    (sinv && st_q == LN_REG && !revoke) |=> st_q == LN_REG); // R6
  AST_SINV_BLOCKS_REQ: assert property (@(posedge clk) disable iff (rst)
    (sinv && !resp_q) |=> !resp_q); // R6
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    resp_q |=> !resp_q); // R10
  AST_FILL_VALID: assert property (@(posedge clk) disable iff (rst)
    (grant && !need_store) |=> st_q == LN_VAL && resp_q); // R2
  AST_STORE_REG: assert property (@(posedge clk) disable iff (rst)
    (grant && need_store) |=> st_q == LN_REG && rdata_q == $past(req_wdata)); // R4
  AST_REVOKE_ONLY_REG: assert property (@(posedge clk) disable iff (rst)
    revoke |-> st_q == LN_REG); // R7
  AST_GRANT_ONLY_NEED: assert property (@(posedge clk) disable iff (rst)
    grant |-> need_dir); // R9
endmodule

// File: rtl/coh_reg_ctrl.sv
module coh_reg_ctrl
  import coh_pkg::*;
#(
  parameter int            NCORE     = 3,
  parameter int            DW        = 16,
  parameter logic [DW-1:0] HOME_INIT = 16'hA5A5,
  localparam int IW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NCORE-1:0]    core_req_valid,
  input  logic [NCORE-1:0]    core_req_store,
  input  logic [NCORE*DW-1:0] core_req_wdata,
  input  logic [NCORE-1:0]    core_sinv,
  output logic [NCORE-1:0]    core_resp_valid,
  output logic [NCORE*DW-1:0] core_resp_rdata,
  output logic [2*NCORE-1:0]  core_line_state
);
  logic [NCORE-1:0]    need_dir, need_store, grant, revoke, is_reg;
  logic [NCORE*DW-1:0] line_data;
  logic [DW-1:0]       fill_data;
  logic [IW-1:0]       gidx, dir_owner;
  logic                gany, dir_reg;
  line_st_t            st [NCORE];

  coh_rr_arb #(.NCORE(NCORE)) u_arb (
    .clk(clk), .rst(rst), .req(need_dir),
    .grant(grant), .gidx(gidx), .gany(gany)
  );

  coh_dir #(.NCORE(NCORE), .DW(DW), .HOME_INIT(HOME_INIT)) u_dir (
    .clk(clk), .rst(rst), .gany(gany), .gidx(gidx),
    .gstore(need_store[gidx]), .line_data(line_data),
    .fill_data(fill_data), .revoke(revoke),
    .dir_reg(dir_reg), .dir_owner(dir_owner)
  );

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    coh_l1_line #(.DW(DW)) u_line (
      .clk(clk), .rst(rst),
      .req_valid(core_req_valid[i]), .req_store(core_req_store[i]),
      .req_wdata(core_req_wdata[i*DW +: DW]), .sinv(core_sinv[i]),
      .need_dir(need_dir[i]), .need_store(need_store[i]),
      .grant(grant[i]), .fill_data(fill_data), .revoke(revoke[i]),
      .line_state(st[i]), .line_data(line_data[i*DW +: DW]),
      .resp_valid(core_resp_valid[i]), .resp_rdata(core_resp_rdata[i*DW +: DW])
    );
    assign core_line_state[2*i +: 2] = st[i];
    assign is_reg[i] = (st[i] == LN_REG);
  end

  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(is_reg)); // R8
  AST_DIR_OWNER_HOLDS: assert property (@(posedge clk) disable iff (rst)
    dir_reg |-> is_reg[dir_owner]); // R8
  AST_HOME_NO_OWNER: assert property (@(posedge clk) disable iff (rst)
    !dir_reg |-> is_reg == '0); // R8
endmodule

// File: tb/sim_coh_reg_ctrl.sv
`timescale 1ns/1ps
module sim_coh_reg_ctrl;
  localparam int NCORE = 3;
  localparam int DW = 16;
  localparam logic [DW-1:0] HINIT = 16'hA5A5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCORE-1:0] req_v = '0, req_st = '0, sinv = '0, manual = '0;
  logic [DW-1:0] req_wd [NCORE];
  logic [NCORE*DW-1:0] wd_bus;
  logic [NCORE-1:0] resp_v;
  logic [NCORE*DW-1:0] resp_d;
  logic [2*NCORE-1:0] lstate;

  always #2.5 clk = ~clk;

  always_comb for (int i = 0; i < NCORE; i++) wd_bus[i*DW +: DW] = req_wd[i];

  coh_reg_ctrl #(.NCORE(NCORE), .DW(DW), .HOME_INIT(HINIT)) u0 (
    .clk(clk), .rst(rst), .core_req_valid(req_v), .core_req_store(req_st),
    .core_req_wdata(wd_bus), .core_sinv(sinv), .core_resp_valid(resp_v),
    .core_resp_rdata(resp_d), .core_line_state(lstate)
  );

  int tests = 0, fails = 0, cyc = 0;
  string tag = "R1";

  task automatic check(string t, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", t, act, exp);
    end
  endtask

  // reference model
  int mst [NCORE];
  logic [DW-1:0] mdat [NCORE], mrd [NCORE];
  bit mresp [NCORE];
  bit dreg;
  int downer, ptr;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCORE; i++) begin
        mst[i] = 0; mdat[i] = '0; mrd[i] = '0; mresp[i] = 0;
      end
      dreg = 0; downer = 0; ptr = NCORE - 1;
    end else begin
      int os [NCORE];
      logic [DW-1:0] od [NCORE];
      bit want [NCORE];
      int g;
      for (int i = 0; i < NCORE; i++) begin
        bit acc;
        os[i] = mst[i]; od[i] = mdat[i];
        acc = req_v[i] && !mresp[i] && !sinv[i];
        want[i] = acc && ((req_st[i] && os[i] != 2) || (!req_st[i] && os[i] == 0));
        mresp[i] = 0;
        if (sinv[i] && os[i] == 1) mst[i] = 0;
        if (acc && !want[i]) begin
          mresp[i] = 1;
          if (req_st[i]) begin mdat[i] = req_wd[i]; mrd[i] = req_wd[i]; end
          else mrd[i] = od[i];
        end
      end
      g = -1;
      for (int k = 1; k <= NCORE; k++) begin
        int idx;
        idx = (ptr + k) % NCORE;
        if (g < 0 && want[idx]) g = idx;
      end
      if (g >= 0) begin
        mresp[g] = 1;
        ptr = g;
        if (req_st[g]) begin
          if (dreg && downer != g) mst[downer] = 0;
          mst[g] = 2; mdat[g] = req_wd[g]; mrd[g] = req_wd[g];
          dreg = 1; downer = g;
        end else begin
          mst[g] = 1;
          mdat[g] = dreg ? od[downer] : HINIT;
          mrd[g] = mdat[g];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < NCORE; i++) begin
        check({tag, " state"}, int'(lstate[2*i +: 2]), mst[i]);
        check({tag, " resp"}, int'(resp_v[i]), int'(mresp[i]));
        if (mresp[i]) check({tag, " rdata"}, int'(resp_d[i*DW +: DW]), int'(mrd[i]));
        if (resp_v[i] && !manual[i]) req_v[i] = 1'b0;
      end
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog R10 act=hung exp=done");
      finish_run();
    end
  end

  task automatic access(int c, bit st, logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output int lat);
    @(negedge clk); #1;
    req_v[c] = 1'b1; req_st[c] = st; req_wd[c] = wd;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!resp_v[c]);
    rd = resp_d[c*DW +: DW];
  endtask

  task automatic pulse_sinv(logic [NCORE-1:0] m);
    @(negedge clk); #1; sinv = m;
    @(negedge clk); #1; sinv = '0;
  endtask

  function automatic int st_of(int c);
    return int'(lstate[2*c +: 2]);
  endfunction

  initial begin
    logic [DW-1:0] rd0, rd1;
    int l0, l1, cnt;
    for (int i = 0; i < NCORE; i++) req_wd[i] = '0;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NCORE; i++) begin
      check("R1 reset state", st_of(i), 0);
      check("R1 reset resp", int'(resp_v[i]), 0);
    end

    tag = "R2";
    access(0, 0, '0, rd0, l0);
    check("R1 home init", int'(rd0), int'(HINIT));
    check("R2 fill latency", l0, 1);
    check("R2 fill state", st_of(0), 1);

    tag = "R5";
    access(0, 0, '0, rd0, l0);
    check("R5 load hit", int'(rd0), int'(HINIT));
    check("R5 hit latency", l0, 1);

    tag = "R4";
    access(1, 1, 16'h1111, rd1, l1);
    check("R4 store rdata", int'(rd1), 16'h1111);
    check("R4 store state", st_of(1), 2);
    tag = "R5";
    access(0, 0, '0, rd0, l0);
    check("R5 stale valid copy", int'(rd0), int'(HINIT));

    tag = "R6";
    pulse_sinv(3'b011);
    @(negedge clk);
    check("R6 valid dropped", st_of(0), 0);
    check("R6 registered kept", st_of(1), 2);

    tag = "R3";
    access(0, 0, '0, rd0, l0);
    check("R3 forwarded data", int'(rd0), 16'h1111);
    check("R3 owner kept", st_of(1), 2);

    tag = "R7";
    access(2, 1, 16'h2222, rd1, l1);
    check("R7 old owner revoked", st_of(1), 0);
    access(1, 0, '0, rd1, l1);
    check("R7 revoked reload", int'(rd1), 16'h2222);

    tag = "R5";
    access(2, 1, 16'h3333, rd1, l1);
    check("R5 store hit latency", l1, 1);
    check("R5 store hit data", int'(rd1), 16'h3333);

    tag = "R9";
    fork
      access(0, 1, 16'h4444, rd0, l0);
      access(1, 1, 16'h5555, rd1, l1);
    join
    check("R9 first winner latency", l0, 1);
    check("R9 loser waits", l1, 2);
    check("R8 last registration owns", st_of(1), 2);
    check("R8 first winner revoked", st_of(0), 0);
    check("R8 earlier owner revoked", st_of(2), 0);
    access(2, 0, '0, rd1, l1);
    check("R3 load from newest owner", int'(rd1), 16'h5555);

    fork
      access(0, 0, '0, rd0, l0);
      access(2, 1, 16'h6666, rd1, l1);
    join
    check("R9 rr load first", l0, 1);
    check("R3 forwarded before re-registration", int'(rd0), 16'h5555);
    check("R9 rr store second", l1, 2);
    check("R7 owner moved", st_of(1), 0);

    tag = "R6";
    fork
      begin @(negedge clk); #1; sinv[0] = 1'b1; @(negedge clk); #1; sinv[0] = 1'b0; end
      access(0, 0, '0, rd0, l0);
    join
    check("R6 request held off by sinv", l0, 2);
    check("R6 refetch after sinv", int'(rd0), 16'h6666);

    tag = "R10";
    @(negedge clk); #1;
    manual[2] = 1'b1; req_st[2] = 1'b0; req_v[2] = 1'b1;
    cnt = 0;
    @(negedge clk); if (resp_v[2]) cnt++;
    @(negedge clk); if (resp_v[2]) cnt++;
    check("R10 no retake in resp cycle", int'(resp_v[2]), 0);
    #1 req_v[2] = 1'b0; manual[2] = 1'b0;
    check("R10 single response", cnt, 1);
    @(negedge clk);
    check("R10 idle after drop", int'(resp_v[2]), 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule